// File: doc/BRIEF.md
# Transmit-Side Cell Bus Polling Master

This block drives the transmit direction of a shared cell bus that serves several PHY devices. It holds one cell queue per port on its own side. It selects a port whose queue holds a complete cell and places that port's number on the polling address bus. It then reads the cell-available reply from the PHY. If the reply is positive, it streams the cell out as a fixed-length run of words. Each word carries a start-of-cell flag, an active-low enable and an odd parity bit.

Polling runs on its own state machine, separate from the word sender. The next port is therefore chosen and asked while the current cell is still on the bus. A port that has already been granted can follow the previous cell with no idle cycle. Ports are offered service in round-robin order. A port whose PHY answers "no room" is passed over for that turn and asked again later.

Top module: `tx_poll_master`

## Requirements
- R1: While rst_ni is low: tx_enb_no is 1, tx_soc_o is 0, tx_data_o is 0, tx_prty_o is 1, tx_addr_o is 8'hFF and q_rd_o is all zero.
- R2: A poll of port p puts the value p on tx_addr_o for exactly two consecutive cycles. The value 8'hFF means no poll. clav_i is taken at the clock edge that ends the second cycle.
- R3: A cell from port p starts only if q_ready_i[p] was high and clav_i was 1 at the end of a poll of p.
- R4: A cell is CELL_WORDS words on consecutive cycles with tx_enb_no low. tx_soc_o is high on the first word only, and at most one q_rd_o bit is high in any cycle. tx_enb_no is high and tx_soc_o is low in every cycle that carries no cell word.
- R5: In every cycle, tx_data_o together with tx_prty_o holds an odd number of ones.
- R6: If every queue stays ready and every PHY answers yes, cells leave in cyclic ascending port order 0, 1, ..., NUM_PORTS-1, 0, ...
- R7: Polling runs while a cell is being sent. A port granted during the transfer has its first word on the cycle right after the last word of the previous cell.
- R8: A port whose PHY answers no sends nothing, and its queue is left untouched. The other ready ports are still served meanwhile.
- R9: Each line word equals the queue head word that was presented when q_rd_o asserted, and appears one cycle later. Every queued cell is sent exactly once, in per-port order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clav_i | input | 1 | Cell-available reply from the addressed PHY |
| q_ready_i | input | NUM_PORTS | Per-port flag: queue holds a complete cell |
| q_data_i | input | NUM_PORTS*DATA_W | Per-port head word of the queue (show-ahead) |
| q_rd_o | output | NUM_PORTS | Per-port pop, one pulse per word sent |
| tx_data_o | output | DATA_W | Line data word (8, 16 or 32 bits) |
| tx_enb_no | output | 1 | Line enable, active low |
| tx_soc_o | output | 1 | Start of cell, high with the first word |
| tx_prty_o | output | 1 | Odd parity over tx_data_o |
| tx_addr_o | output | 8 | PHY polling address, 8'hFF when idle |

## Verification
Polling and word transfer can share a cycle. The poll of the next port, the reply on clav_i and the grant all fall inside the words of the current cell. The handover happens on the very edge that retires that cell's last word. The bench provokes this by keeping every queue full with all PHYs answering yes. It then requires an unbroken word stream whose start-of-cell marks follow the round-robin order. It also requires that every start matches a positive reply logged for that port during its own poll. Random phases change PHY space while polls are in flight, so a reply can flip between the address cycle and the sampling cycle.

// File: rtl/tx_poll_pkg.sv
package tx_poll_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] NULL_ADDR = 8'hFF;

  typedef enum logic [1:0] {
    P_IDLE,
    P_ADDR,
    P_WAIT,
    P_HIT
  } poll_st_e;
endpackage

// File: rtl/tx_rr_pick.sv
module tx_rr_pick #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic [NUM_PORTS-1:0] req_i,
  input  logic [IDX_W-1:0]     ptr_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);
  // first requester at or after ptr_i, wrapping
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int k = NUM_PORTS - 1; k >= 0; k--) begin
      int j;
      j = int'(ptr_i) + k;
      if (j >= int'(NUM_PORTS)) j = j - int'(NUM_PORTS);
      if (req_i[j]) idx_o = IDX_W'(j);
    end
  end
endmodule

// File: rtl/tx_poll_fsm.sv
module tx_poll_fsm
  import tx_poll_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clav_i,
  input  logic [NUM_PORTS-1:0] ready_i,
  input  logic                 busy_i,
  input  logic [IDX_W-1:0]     busy_port_i,
  input  logic                 start_ok_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 grant_o,
  output logic [IDX_W-1:0]     grant_port_o
);
  poll_st_e              st_q;
  logic [IDX_W-1:0]      cand_q, rr_q, pick_idx, cand_inc;
  logic [NUM_PORTS-1:0]  busy_mask, elig;
  logic                  pick_found;

  // port on the bus is not polled again until its cell is out
  assign busy_mask = busy_i ? ({{(NUM_PORTS-1){1'b0}}, 1'b1} << busy_port_i) : '0;
  assign elig      = ready_i & ~busy_mask;
  assign cand_inc  = (cand_q == IDX_W'(NUM_PORTS - 1)) ? '0 : cand_q + 1'b1;

  tx_rr_pick #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_pick (
    .req_i   (elig),
    .ptr_i   (rr_q),
    .found_o (pick_found),
    .idx_o   (pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= P_IDLE;
      cand_q <= '0;
      rr_q   <= '0;
    end else begin
      unique case (st_q)
        P_IDLE: if (pick_found) begin
          cand_q <= pick_idx;
          st_q   <= P_ADDR;
        end
        P_ADDR: st_q <= P_WAIT;
        P_WAIT: begin
          if (clav_i && ready_i[cand_q]) begin
            st_q <= P_HIT;
          end else begin
            st_q <= P_IDLE;
            rr_q <= cand_inc;
          end
        end
        P_HIT: if (start_ok_i) begin
          st_q <= P_IDLE;
          rr_q <= cand_inc;
        end
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign addr_o       = (st_q == P_ADDR || st_q == P_WAIT) ? ADDR_W'(cand_q) : NULL_ADDR;
  assign grant_o      = (st_q == P_HIT) && start_ok_i;
  assign grant_port_o = cand_q;

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == P_WAIT) |-> ($stable(addr_o) && addr_o != NULL_ADDR)); // R2
  AST_HIT_NEEDS_CLAV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == P_HIT && $past(st_q) == P_WAIT) |-> $past(clav_i)); // R3
endmodule

// File: rtl/tx_cell_sender.sv
module tx_cell_sender #(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CELL_WORDS = 12,
  parameter int unsigned IDX_W      = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [IDX_W-1:0]            start_port_i,
  input  logic [NUM_PORTS*DATA_W-1:0] q_data_i,
  output logic                        busy_o,
  output logic [IDX_W-1:0]            port_o,
  output logic                        last_o,
  output logic [NUM_PORTS-1:0]        q_rd_o,
  output logic [DATA_W-1:0]           tx_data_o,
  output logic                        tx_enb_no,
  output logic                        tx_soc_o,
  output logic                        tx_prty_o
);
  localparam int unsigned CNT_W = (CELL_WORDS > 1) ? $clog2(CELL_WORDS) : 1;

  logic              busy_q;
  logic [IDX_W-1:0]  port_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] word_nxt;

  assign last_o   = busy_q && (cnt_q == CNT_W'(CELL_WORDS - 1));
  assign busy_o   = busy_q;
  assign port_o   = port_q;
  assign word_nxt = busy_q ? q_data_i[port_q*DATA_W +: DATA_W] : '0;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_rd
    assign q_rd_o[g] = busy_q && (port_q == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      port_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      port_q <= start_port_i;
      cnt_q  <= '0;
    end else if (last_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // registered line side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_data_o <= '0;
      tx_enb_no <= 1'b1;
      tx_soc_o  <= 1'b0;
      tx_prty_o <= 1'b1;
    end else begin
      tx_data_o <= word_nxt;
      tx_enb_no <= !busy_q;
      tx_soc_o  <= busy_q && (cnt_q == '0);
      tx_prty_o <= ~^word_nxt;
    end
  end

  AST_RD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(q_rd_o)); // R4
  AST_CELL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> busy_q); // R4
  AST_SOC_ENB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_soc_o |-> !tx_enb_no); // R4
  AST_ODD_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^{tx_data_o, tx_prty_o}) == 1'b1); // R5
  AST_START_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (!busy_q || last_o)); // R7
endmodule

// File: rtl/tx_poll_master.sv
module tx_poll_master
  import tx_poll_pkg::*;
#(
  parameter int unsigned NUM_PORTS  = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned CELL_WORDS = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clav_i,
  input  logic [NUM_PORTS-1:0]        q_ready_i,
  input  logic [NUM_PORTS*DATA_W-1:0] q_data_i,
  output logic [NUM_PORTS-1:0]        q_rd_o,
  output logic [DATA_W-1:0]           tx_data_o,
  output logic                        tx_enb_no,
  output logic                        tx_soc_o,
  output logic                        tx_prty_o,
  output logic [7:0]                  tx_addr_o
);
  localparam int unsigned IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic             busy, last, grant;
  logic [IDX_W-1:0] busy_port, grant_port;

  tx_poll_fsm #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) u_poll (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clav_i       (clav_i),
    .ready_i      (q_ready_i),
    .busy_i       (busy),
    .busy_port_i  (busy_port),
    .start_ok_i   (!busy || last),
    .addr_o       (tx_addr_o),
    .grant_o      (grant),
    .grant_port_o (grant_port)
  );

  tx_cell_sender #(
    .NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .CELL_WORDS(CELL_WORDS), .IDX_W(IDX_W)
  ) u_send (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (grant),
    .start_port_i (grant_port),
    .q_data_i     (q_data_i),
    .busy_o       (busy),
    .port_o       (busy_port),
    .last_o       (last),
    .q_rd_o       (q_rd_o),
    .tx_data_o    (tx_data_o),
    .tx_enb_no    (tx_enb_no),
    .tx_soc_o     (tx_soc_o),
    .tx_prty_o    (tx_prty_o)
  );
endmodule

// File: tb/tx_poll_master_bench.sv
module tx_poll_master_bench;
  localparam int N  = 4;
  localparam int DW = 32;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          clav;
  logic [N-1:0]  q_ready, q_rd;
  logic [N*DW-1:0] q_data;
  logic [DW-1:0] tx_data;
  logic          tx_enb_n, tx_soc, tx_prty;
  logic [7:0]    tx_addr;

  tx_poll_master #(.NUM_PORTS(N), .DATA_W(DW), .CELL_WORDS(CW)) u_tx_poll_master (
    .clk_i(clk), .rst_ni(rst_n), .clav_i(clav), .q_ready_i(q_ready), .q_data_i(q_data),
    .q_rd_o(q_rd), .tx_data_o(tx_data), .tx_enb_no(tx_enb_n), .tx_soc_o(tx_soc),
    .tx_prty_o(tx_prty), .tx_addr_o(tx_addr)
  );

  int cells[N], seqn[N], widx[N];
  bit space[N], resp[N];
  int n_chk, n_fail, cyc;
  bit pend_vld;
  int pend_port;
  int order[$];
  int queued_total, sent_total;
  int addr_run;
  logic [7:0] addr_prev;
  int words_seen, first_w, last_w;
  int arrive_pm;

  function automatic logic [DW-1:0] word_of(int p, int s, int w);
    return {8'(p), 8'(s), 16'(w)};
  endfunction

  task automatic chk(bit ok, string req, string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  task automatic tick();
    bit ev, es;
    int pp;
    logic [DW-1:0] ew;
    @(negedge clk);
    cyc++;
    ev = pend_vld; pp = pend_port; es = 1'b0; ew = '0;
    if (ev) begin
      ew = word_of(pp, seqn[pp], widx[pp]);
      es = (widx[pp] == 0);
      widx[pp]++;
      if (widx[pp] == CW) begin
        widx[pp] = 0; seqn[pp] = (seqn[pp] + 1) % 256; cells[pp]--; sent_total++;
      end
    end
    if (ev) begin
      chk(tx_enb_n == 1'b0, "R4", $sformatf("enb_n act %0b exp 0", tx_enb_n));
      chk(tx_data == ew, "R9", $sformatf("data act %h exp %h", tx_data, ew));
      chk(tx_soc == es, "R4", $sformatf("soc act %0b exp %0b", tx_soc, es));
      if (es) begin
        chk(resp[pp], "R3", $sformatf("port %0d started, clav reply act 0 exp 1", pp));
        order.push_back(pp);
      end
      if (words_seen == 0) first_w = cyc;
      last_w = cyc;
      words_seen++;
    end else begin
      chk(tx_enb_n == 1'b1 && tx_soc == 1'b0, "R4",
          $sformatf("idle enb_n/soc act %0b/%0b exp 1/0", tx_enb_n, tx_soc));
    end
    chk((^{tx_data, tx_prty}) == 1'b1, "R5",
        $sformatf("parity act %0b exp %0b", tx_prty, ~^tx_data));
    if (tx_addr != 8'hFF) begin
      chk(int'(tx_addr) < N, "R2", $sformatf("addr act %0d exp <%0d", tx_addr, N));
      if (addr_run > 0 && tx_addr != addr_prev) begin
        chk(addr_run == 2, "R2", $sformatf("poll length act %0d exp 2", addr_run));
        addr_run = 0;
      end
      addr_run++;
    end else begin
      if (addr_run > 0) chk(addr_run == 2, "R2", $sformatf("poll length act %0d exp 2", addr_run));
      addr_run = 0;
    end
    addr_prev = tx_addr;
    if (arrive_pm > 0 && $urandom_range(999, 0) < arrive_pm) begin
      int p;
      p = $urandom_range(N - 1, 0);
      if (cells[p] < 4) begin cells[p]++; queued_total++; end
    end
    for (int p = 0; p < N; p++) begin
      q_ready[p] = cells[p] > 0;
      q_data[p*DW +: DW] = word_of(p, seqn[p], widx[p]);
    end
    if (int'(tx_addr) < N) begin
      clav = space[tx_addr[1:0]];
      resp[tx_addr[1:0]] = clav;
    end else clav = 1'b0;
    chk($countones(q_rd) <= 1, "R4", $sformatf("q_rd act %b exp onehot0", q_rd));
    pend_vld = |q_rd;
    pend_port = 0;
    for (int p = 0; p < N; p++) if (q_rd[p]) pend_port = p;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (guard < 3000 && !(cells[0] == 0 && cells[1] == 0 && cells[2] == 0 && cells[3] == 0 && !pend_vld)) begin
      tick(); guard++;
    end
    repeat (4) tick();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9: watchdog act hung exp finished");
    summary();
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'h5eed_0042));
    clav = 1'b0; q_ready = '0; q_data = '0;
    for (int p = 0; p < N; p++) begin cells[p] = 0; seqn[p] = 0; widx[p] = 0; space[p] = 1'b1; resp[p] = 1'b0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_enb_n == 1'b1 && tx_soc == 1'b0, "R1", $sformatf("enb_n/soc act %0b/%0b exp 1/0", tx_enb_n, tx_soc));
    chk(tx_data == '0 && tx_prty == 1'b1, "R1", $sformatf("data/prty act %h/%0b exp 0/1", tx_data, tx_prty));
    chk(tx_addr == 8'hFF && q_rd == '0, "R1", $sformatf("addr/rd act %h/%b exp ff/0", tx_addr, q_rd));
    rst_n = 1'b1;

    // R6 R7: saturated, all PHYs have room
    for (int p = 0; p < N; p++) begin cells[p] = 3; queued_total += 3; end
    words_seen = 0; order.delete();
    drain();
    chk(order.size() == 3 * N, "R6", $sformatf("cells act %0d exp %0d", order.size(), 3 * N));
    ok = 1'b1;
    foreach (order[i]) if (order[i] != i % N) ok = 1'b0;
    chk(ok, "R6", $sformatf("order act %p exp cyclic ascending", order));
    chk(last_w - first_w + 1 == words_seen, "R7",
        $sformatf("span act %0d exp %0d", last_w - first_w + 1, words_seen));

    // R8: PHY 1 refuses
    order.delete();
    space[1] = 1'b0;
    cells[1] += 1; cells[2] += 2; queued_total += 3;
    repeat (300) tick();
    chk(cells[1] == 1 && widx[1] == 0, "R8", $sformatf("port1 cells/word act %0d/%0d exp 1/0", cells[1], widx[1]));
    chk(cells[2] == 0, "R8", $sformatf("port2 cells act %0d exp 0", cells[2]));
    ok = 1'b1;
    foreach (order[i]) if (order[i] == 1) ok = 1'b0;
    chk(ok, "R8", $sformatf("order act %p exp no port 1", order));
    space[1] = 1'b1;
    drain();
    chk(cells[1] == 0, "R8", $sformatf("port1 after release act %0d exp 0", cells[1]));

    // random traffic with moving PHY space
    arrive_pm = 30;
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0)
        for (int p = 0; p < N; p++) space[p] = ($urandom_range(3, 0) != 0);
      tick();
    end
    arrive_pm = 0;
    for (int p = 0; p < N; p++) space[p] = 1'b1;
    drain();
    chk(sent_total == queued_total, "R9", $sformatf("sent act %0d exp %0d", sent_total, queued_total));
    chk(cells[0] + cells[1] + cells[2] + cells[3] == 0, "R9", "queues left act nonempty exp empty");
    summary();
    $finish;
  end
endmodule